// File: doc/BRIEF.md
# Port Status and Control Register for a Dual-Role USB Port

This block holds the status and control word of one USB-style port. The port can act as host or as device, and the `is_host` input picks the role. Software reads the whole word combinationally on `rd_data`. It writes the word in a single cycle through `wr_en` and `wr_data`. Whether a field can be written, or only mirrors a line from the bus side, depends on the role.

The bus side feeds in an asynchronous power-fault line, a high-speed indication, a bus-reset indication and a device-side suspend indication. The power-fault line passes through a two-flop synchronizer and becomes the over-current active bit. Any change of that bit sets a sticky over-current change bit, which software clears by writing 1 to it. A hardware change in the same cycle as the clear wins. The port reset bit is forced to 0 whenever the port power bit is 0.

A small state machine follows the enable and suspend bits and reports the port as disabled, enabled or suspended. Its transitions are named ENABLE (disabled to enabled), SUSPEND (enabled to suspended), RESUME (suspended to enabled), DISABLE (enabled or suspended to disabled) and DIRECT_SUSPEND (disabled to suspended, when both bits are set in one write). The reset, suspend and force-resume controls are also driven out as plain outputs.

Top module: `port_status_ctl`

## Requirements
- R1: After reset, every bit of `rd_data` is 0, `port_state_o` is DISABLED, and `port_reset_o`, `suspend_o` and `resume_o` are 0.
- R2: Bit 7 (high-speed) reads the value of `hs_line` registered once, with 1 for high speed and 0 for low or full speed. Writes to bit 7 are ignored.
- R3: Bit 0 is port power. Bit 3 (port reset) is writable in host role and reads 0 whenever port power is 0, including when a write sets bit 3 while clearing bit 0.
- R4: In device role, bit 3 reads `bus_reset` registered once (gated by power) and bit 2 reads `dev_suspend` registered once. Software writes to bits 2 and 3 are ignored in that role.
- R5: `port_state_o` is derived from bit 1 (enable) and bit 2 (suspend). Enable 0 gives DISABLED (0), enable 1 with suspend 0 gives ENABLED (1), and both set gives SUSPENDED (2). The state updates one clock after the bits.
- R6: Bit 4 (force resume) is read/write in both roles and drives `resume_o`.
- R7: Bit 5 (over-current active) follows `pwr_fault` through two flops: it reads the new level after the second rising edge, and it returns to 0 on its own when the fault clears. Writes to bit 5 are ignored.
- R8: Bit 6 (over-current change) becomes 1 one edge after bit 5 changes in either direction. Writing 1 to bit 6 clears it. Writing 0 to bit 6 leaves it unchanged.
- R9: If a change event and a write of 1 to bit 6 fall in the same cycle, bit 6 ends up 1.
- R10: In device role, bits 5 and 6 read 0 whatever `pwr_fault` does.
- R11: `port_reset_o` and `suspend_o` equal the values read in bits 3 and 2. Bits above 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| is_host | input | 1 | 1 selects host role, 0 selects device role |
| wr_en | input | 1 | Write strobe for the register word |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Current register word |
| pwr_fault | input | 1 | Asynchronous over-current fault line |
| hs_line | input | 1 | High-speed indication from the line |
| bus_reset | input | 1 | Bus reset seen in device role |
| dev_suspend | input | 1 | Bus suspend seen in device role |
| port_reset_o | output | 1 | Port reset control |
| suspend_o | output | 1 | Suspend control/status |
| resume_o | output | 1 | Force-resume control |
| port_state_o | output | 2 | Decoded port state (0 disabled, 1 enabled, 2 suspended) |

## Verification
Written fields, and the registered copies of `hs_line`, `bus_reset` and `dev_suspend`, are visible on `rd_data` one edge after the stimulus. `port_state_o` follows one edge later again. Over-current active appears two edges after `pwr_fault` moves, and the change bit appears on the third edge. Every expectation is queued one time unit after a falling edge and compared at the next falling edge, so it always covers exactly one rising edge. The bench waits through the extra edges with single-edge expectations that hold the intermediate values, which pins down the two-edge and three-edge latencies. The same-cycle case holds the clearing write across the edge on which the change event is due.

// File: rtl/port_ctl_pkg.sv
package port_ctl_pkg;

    typedef enum logic [1:0] {
        PS_DISABLED  = 2'd0,
        PS_ENABLED   = 2'd1,
        PS_SUSPENDED = 2'd2
    } port_state_e;

    localparam int B_PWR  = 0;
    localparam int B_EN   = 1;
    localparam int B_SUSP = 2;
    localparam int B_RST  = 3;
    localparam int B_FRES = 4;
    localparam int B_OCA  = 5;
    localparam int B_OCC  = 6;
    localparam int B_HS   = 7;
    localparam int FIELD_W = 8;

endpackage

// File: rtl/pfault_sync.sv
module pfault_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic change_o
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] chain_q;
    logic         prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= async_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[TOP-1:0], async_i};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[TOP];
    end

    assign level_o  = chain_q[TOP];
    assign change_o = chain_q[TOP] ^ prev_q;

    // R8: a change pulse means the remembered level trails the live one
    a_r8_change_prev: assert property (@(posedge clk) disable iff (!rst_n)
        change_o |=> (prev_q == $past(level_o)));

endmodule

// File: rtl/port_state_fsm.sv
module port_state_fsm
    import port_ctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en_i,
    input  logic        susp_i,
    output logic [1:0]  state_o
);
    port_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_DISABLED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_DISABLED: begin
                if (en_i && susp_i) state_d = PS_SUSPENDED;  // DIRECT_SUSPEND
                else if (en_i)      state_d = PS_ENABLED;    // ENABLE
            end
            PS_ENABLED: begin
                if (!en_i)          state_d = PS_DISABLED;   // DISABLE
                else if (susp_i)    state_d = PS_SUSPENDED;  // SUSPEND
            end
            PS_SUSPENDED: begin
                if (!en_i)          state_d = PS_DISABLED;   // DISABLE
                else if (!susp_i)   state_d = PS_ENABLED;    // RESUME
            end
            default:                state_d = PS_DISABLED;
        endcase
    end

    always_comb begin
        state_o = state_q;
    end

    // R5: suspended only when both bits were set on the previous edge
    a_r5_susp_state: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_SUSPENDED) |-> $past(en_i && susp_i));

    // R5: enable low always lands in disabled
    a_r5_disable: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (state_q == PS_DISABLED));

endmodule

// File: rtl/port_status_ctl.sv
module port_status_ctl
    import port_ctl_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_host,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              pwr_fault,
    input  logic              hs_line,
    input  logic              bus_reset,
    input  logic              dev_suspend,
    output logic              port_reset_o,
    output logic              suspend_o,
    output logic              resume_o,
    output logic [1:0]        port_state_o
);
    localparam int PAD_W = DATA_W - FIELD_W;

    logic pwr_q, en_q, susp_q, rst_q, fres_q, occ_q, hs_q;
    logic pwr_d;
    logic oc_level, oc_change;
    logic occ_clear;

    pfault_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_i  (pwr_fault),
        .level_o  (oc_level),
        .change_o (oc_change)
    );

    port_state_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (en_q),
        .susp_i  (susp_q),
        .state_o (port_state_o)
    );

    assign pwr_d     = wr_en ? wr_data[B_PWR] : pwr_q;
    assign occ_clear = wr_en && wr_data[B_OCC];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_q  <= 1'b0;
            en_q   <= 1'b0;
            susp_q <= 1'b0;
            rst_q  <= 1'b0;
            fres_q <= 1'b0;
            hs_q   <= 1'b0;
        end else begin
            pwr_q <= pwr_d;
            hs_q  <= hs_line;
            if (wr_en) begin
                en_q   <= wr_data[B_EN];
                fres_q <= wr_data[B_FRES];
            end
            if (is_host) begin
                if (wr_en) susp_q <= wr_data[B_SUSP];
                if (!pwr_d)     rst_q <= 1'b0;
                else if (wr_en) rst_q <= wr_data[B_RST];
            end else begin
                susp_q <= dev_suspend;
                rst_q  <= bus_reset & pwr_d;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)          occ_q <= 1'b0;
        else if (!is_host)   occ_q <= 1'b0;
        else if (oc_change)  occ_q <= 1'b1;
        else if (occ_clear)  occ_q <= 1'b0;
    end

    logic [FIELD_W-1:0] fields;
    always_comb begin
        fields         = '0;
        fields[B_PWR]  = pwr_q;
        fields[B_EN]   = en_q;
        fields[B_SUSP] = susp_q;
        fields[B_RST]  = rst_q & pwr_q;
        fields[B_FRES] = fres_q;
        fields[B_OCA]  = is_host & oc_level;
        fields[B_OCC]  = is_host & occ_q;
        fields[B_HS]   = hs_q;
    end

    generate
        if (PAD_W > 0) begin : g_pad
            assign rd_data = {{PAD_W{1'b0}}, fields};
        end else begin : g_nopad
            assign rd_data = fields[DATA_W-1:0];
        end
    endgenerate

    assign port_reset_o = rst_q & pwr_q;
    assign suspend_o    = susp_q;
    assign resume_o     = fres_q;

    // R3: a held reset always has power behind it
    a_r3_rst_powered: assert property (@(posedge clk) disable iff (!rst_n)
        rst_q |-> pwr_q);

    // R8: a change event in host role sets the sticky bit
    a_r8_occ_set: assert property (@(posedge clk) disable iff (!rst_n)
        (is_host && oc_change) |=> occ_q);

    // R8: a write of one with no event clears the sticky bit
    a_r8_occ_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (is_host && occ_clear && !oc_change) |=> !occ_q);

    // R10: device role keeps the sticky bit low
    a_r10_dev_occ: assert property (@(posedge clk) disable iff (!rst_n)
        !is_host |=> !occ_q);

    // R6: force resume follows the written value
    a_r6_fres_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (resume_o == $past(wr_data[B_FRES])));

endmodule

// File: tb/port_status_ctl_tb_top.sv
module port_status_ctl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       is_host = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       pwr_fault = 1'b0;
    logic       hs_line = 1'b0;
    logic       bus_reset = 1'b0;
    logic       dev_suspend = 1'b0;
    logic       port_reset_o, suspend_o, resume_o;
    logic [1:0] port_state_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    port_status_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .is_host(is_host), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .pwr_fault(pwr_fault),
        .hs_line(hs_line), .bus_reset(bus_reset), .dev_suspend(dev_suspend),
        .port_reset_o(port_reset_o), .suspend_o(suspend_o),
        .resume_o(resume_o), .port_state_o(port_state_o)
    );

    typedef struct {
        int         kind;
        logic [7:0] mask;
        logic [7:0] exp;
        string      tag;
    } exp_t;

    exp_t sb_q[$];

    // kind 0: rd_data & mask, kind 1: port state, kind 2: {reset, suspend, resume}
    task automatic expect_val(input int kind, input logic [7:0] mask,
                              input logic [7:0] exp, input string tag);
        exp_t it;
        #1;
        it.kind = kind; it.mask = mask; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                exp_t it;
                logic [7:0] got;
                it = sb_q.pop_front();
                case (it.kind)
                    0:       got = rd_data & it.mask;
                    1:       got = {6'd0, port_state_o};
                    default: got = {5'd0, port_reset_o, suspend_o, resume_o};
                endcase
                n_checks++;
                if (got !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        expect_val(0, 8'hFF, 8'h00, "R1 rd_data");
        expect_val(1, 8'hFF, 8'h00, "R1 state");
        expect_val(2, 8'hFF, 8'h00, "R1 outputs");

        // R5 state decoding, R11 outputs mirror
        reg_write(8'h03);
        expect_val(0, 8'h07, 8'h03, "R5 enable bits");
        expect_val(1, 8'hFF, 8'h01, "R5 enabled");
        reg_write(8'h07);
        expect_val(1, 8'hFF, 8'h02, "R5 suspended");
        expect_val(2, 8'hFF, 8'h02, "R11 suspend_o");
        reg_write(8'h05);
        expect_val(1, 8'hFF, 8'h00, "R5 disabled with suspend");

        // R3 power gating of reset
        reg_write(8'h08);
        expect_val(0, 8'h09, 8'h00, "R3 reset without power");
        reg_write(8'h09);
        expect_val(0, 8'h09, 8'h09, "R3 reset with power");
        expect_val(2, 8'h04, 8'h04, "R11 port_reset_o");
        reg_write(8'h08);
        expect_val(0, 8'h09, 8'h00, "R3 power off clears reset");

        // R2 speed bit, ignored writes to bits 7 and 5, R11 upper bits
        reg_write(8'hA0);
        expect_val(0, 8'hFF, 8'h00, "R2 ro bits ignore writes");
        hs_line = 1'b1;
        expect_val(0, 8'h80, 8'h80, "R2 high speed");
        hs_line = 1'b0;
        expect_val(0, 8'h80, 8'h00, "R2 low/full speed");

        // R6 force resume
        reg_write(8'h10);
        expect_val(0, 8'h10, 8'h10, "R6 resume bit");
        expect_val(2, 8'h01, 8'h01, "R6 resume_o");
        reg_write(8'h00);
        expect_val(2, 8'h01, 8'h00, "R6 resume_o cleared");

        // R7/R8 fault rise timing
        pwr_fault = 1'b1;
        expect_val(0, 8'h60, 8'h00, "R7 after one edge");
        expect_val(0, 8'h60, 8'h20, "R7 after two edges");
        expect_val(0, 8'h60, 8'h60, "R8 change set");
        reg_write(8'h00);
        expect_val(0, 8'h40, 8'h40, "R8 write zero keeps change");
        reg_write(8'h40);
        expect_val(0, 8'h60, 8'h20, "R8 write one clears change");

        // R9 fall event coinciding with a clear
        pwr_fault = 1'b0;
        @(negedge clk);
        @(negedge clk);
        reg_write(8'h40);
        expect_val(0, 8'h60, 8'h40, "R9 set wins over clear");
        expect_val(0, 8'h20, 8'h00, "R7 active self-clears");

        // R10 device role hides over-current
        is_host = 1'b0;
        pwr_fault = 1'b1;
        repeat (4) @(negedge clk);
        expect_val(0, 8'h60, 8'h00, "R10 device over-current zero");

        // R4 device role reset/suspend status
        reg_write(8'h0F);
        expect_val(0, 8'h0C, 8'h00, "R4 device ignores writes");
        bus_reset = 1'b1;
        dev_suspend = 1'b1;
        expect_val(0, 8'h0C, 8'h0C, "R4 device status bits");
        expect_val(2, 8'h06, 8'h06, "R11 device outputs");
        bus_reset = 1'b0;
        dev_suspend = 1'b0;
        expect_val(0, 8'h0C, 8'h00, "R4 device status cleared");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule